// File: doc/BRIEF.md
# Channelized System Trace Message Generator

This block is a memory-mapped trace source that sits on a processor's write path. Software writes values into a stimulus address window. The window is divided into numbered channels of 256 bytes each. Each accepted write that lands in the window becomes exactly one trace message. The message carries the channel number taken from the write address, the written data trimmed to the write size, and an optional 32-bit timestamp. It can also carry a marker flag, which a receiver uses to frame multi-message sequences such as the final piece of a string.

The write side is a simple write-only bus with valid/ready. Its signals are address, 64-bit data and a 2-bit size code. Messages leave through a valid/ready stream. A four-entry queue sits between the two sides. When that queue is full, the write side stalls instead of losing a message. Writes that miss the window are still accepted, but they produce no message and set a sticky error flag.

An ingress state machine controls write acceptance. It has two states:
- `ING_OPEN`: the queue has room and `wr_ready` is high.
- `ING_BLOCKED`: the queue is full and `wr_ready` is low.

It has two transitions:
- `fill`: OPEN to BLOCKED, when a write is queued with no message leaving and the queue holds DEPTH-1 entries.
- `drain`: BLOCKED to OPEN, when a message leaves.

Top module: `sys_trace_gen`

## Requirements
- R1: A write hits the window when address bits [31:12] equal 0x40000. Its message carries address bits [11:8] as the channel number, giving 16 channels of 256 bytes.
- R2: Every accepted in-window write produces exactly one message. Messages leave in the order the writes were accepted.
- R3: Address bits [4:3] select the message variant: 0 = plain, 1 = timestamped, 2 = marker, 3 = timestamped with marker. Address bits [7:5] and [2:0] have no effect on the message.
- R4: `wr_size` codes 0/1/2/3 mean 8/16/32/64 data bits, and `msg_size` repeats the code. Data bits above the size are zero in the message.
- R5: Stamped messages carry a free-running 32-bit counter, sampled in the accepting cycle. Two stamped writes accepted k cycles apart differ by k. Unstamped messages carry `msg_ts_en`=0 and `msg_ts`=0.
- R6: With `msg_ready` held low, four writes are accepted and `wr_ready` then goes low. No message is lost.
- R7: While `msg_valid` is high and `msg_ready` is low, the message fields stay stable.
- R8: A write outside the window is accepted but adds no message. `err_sticky` is high from the next cycle on, until reset.
- R9: After reset, `msg_valid`=0, `err_sticky`=0 and `wr_ready`=1.
- R10: In the cycle after a message leaves a full queue (the `drain` transition), `wr_ready` is high again. An empty queue always has `wr_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 64 | Write data, low lanes used for narrow sizes |
| wr_size | input | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bits |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Sink takes the message |
| msg_chan | output | 4 | Channel number |
| msg_data | output | 64 | Message data, zero above the size |
| msg_size | output | 2 | Size code of the message |
| msg_ts_en | output | 1 | Message carries a timestamp |
| msg_ts | output | 32 | Timestamp, zero when not stamped |
| msg_marker | output | 1 | Framing marker flag |
| err_sticky | output | 1 | A write missed the window since reset |

## Verification
The assertions check the following on every cycle:
- message fields stay stable while backpressured;
- the error flag sets after a missed write and then stays set;
- an empty queue never stalls the writer;
- a missed write never creates a message;
- the upper data bits of a narrow message are zero;
- an unstamped message has a zero timestamp.

Some behaviours can only be shown by the directed scenarios:
- that channel numbers and variants decode from the address;
- that message order follows write order across a full queue;
- that exactly four writes fit before the stall;
- the cycle distance between two timestamps.

// File: rtl/stg_pkg.sv
package stg_pkg;

    localparam int STG_DATA_W   = 64;
    localparam int STG_TS_W     = 32;
    localparam int STG_CH_MAX_W = 8;
    localparam int STG_LANES    = STG_DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        VAR_PLAIN = 2'd0,
        VAR_STAMP = 2'd1,
        VAR_MARK  = 2'd2,
        VAR_BOTH  = 2'd3
    } variant_e;

    typedef enum logic {
        ING_OPEN    = 1'b0,
        ING_BLOCKED = 1'b1
    } ing_state_e;

    typedef struct packed {
        logic [STG_CH_MAX_W-1:0] chan;
        logic [STG_DATA_W-1:0]   data;
        size_e                   size;
        logic                    ts_en;
        logic [STG_TS_W-1:0]     ts;
        logic                    marker;
    } msg_t;

endpackage

// File: rtl/stg_addr_decode.sv
module stg_addr_decode
    import stg_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          CH_W     = 4,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [STG_DATA_W-1:0] data_i,
    input  size_e                 size_i,
    output logic                  in_win_o,
    output logic [CH_W-1:0]       chan_o,
    output variant_e              variant_o,
    output logic [STG_DATA_W-1:0] data_o
);

    localparam int HI_LSB = CH_W + 8;

    logic [ADDR_W-1:0]    base_ext;
    logic [STG_LANES-1:0] lane_on;
    logic [4:0]           lane_lim;
    logic                 unused_addr_bits;

    assign base_ext  = ADDR_W'(WIN_BASE);
    assign in_win_o  = (addr_i >> HI_LSB) == (base_ext >> HI_LSB);
    assign chan_o    = addr_i[HI_LSB-1:8];
    assign variant_o = variant_e'(addr_i[4:3]);
    assign lane_lim  = 5'd1 << size_i;

    assign unused_addr_bits = ^{addr_i[7:5], addr_i[2:0]};

    for (genvar b = 0; b < STG_LANES; b++) begin : g_lane
        assign lane_on[b]       = 5'(b) < lane_lim;
        assign data_o[8*b +: 8] = lane_on[b] ? data_i[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/stg_tstamp.sv
module stg_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] count_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/stg_msg_fifo.sv
module stg_msg_fifo
    import stg_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  msg_t             din_i,
    input  logic             pop_i,
    output msg_t             dout_o,
    output logic             empty_o,
    output logic [CNT_W-1:0] count_o
);

    msg_t             mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[wptr_q] <= din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_o <= '0;
        end else begin
            if (push_i) begin
                wptr_q <= ptr_next(wptr_q);
            end
            if (pop_i) begin
                rptr_q <= ptr_next(rptr_q);
            end
            unique case ({push_i, pop_i})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    assign dout_o  = mem_q[rptr_q];
    assign empty_o = (count_o == '0);

endmodule

// File: rtl/sys_trace_gen.sv
module sys_trace_gen
    import stg_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          CH_W     = 4,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000,
    parameter int          DEPTH    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [STG_DATA_W-1:0] wr_data,
    input  logic [1:0]            wr_size,
    output logic                  msg_valid,
    input  logic                  msg_ready,
    output logic [CH_W-1:0]       msg_chan,
    output logic [STG_DATA_W-1:0] msg_data,
    output logic [1:0]            msg_size,
    output logic                  msg_ts_en,
    output logic [STG_TS_W-1:0]   msg_ts,
    output logic                  msg_marker,
    output logic                  err_sticky
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    ing_state_e state_q, state_d;

    logic                  in_win;
    logic [CH_W-1:0]       dec_chan;
    variant_e              dec_var;
    logic [STG_DATA_W-1:0] dec_data;
    logic [STG_TS_W-1:0]   ts_now;
    logic                  accept;
    logic                  push;
    logic                  pop;
    logic                  fifo_empty;
    logic [CNT_W-1:0]      fifo_count;
    msg_t                  new_msg;
    msg_t                  head_msg;
    logic                  err_q;
    logic                  unused_head;

    stg_addr_decode #(
        .ADDR_W  (ADDR_W),
        .CH_W    (CH_W),
        .WIN_BASE(WIN_BASE)
    ) u_decode (
        .addr_i   (wr_addr),
        .data_i   (wr_data),
        .size_i   (size_e'(wr_size)),
        .in_win_o (in_win),
        .chan_o   (dec_chan),
        .variant_o(dec_var),
        .data_o   (dec_data)
    );

    stg_tstamp #(
        .TS_W(STG_TS_W)
    ) u_tstamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .count_o(ts_now)
    );

    always_comb begin
        new_msg              = '0;
        new_msg.chan[CH_W-1:0] = dec_chan;
        new_msg.data         = dec_data;
        new_msg.size         = size_e'(wr_size);
        unique case (dec_var)
            VAR_PLAIN: begin
                new_msg.ts_en  = 1'b0;
                new_msg.marker = 1'b0;
            end
            VAR_STAMP: begin
                new_msg.ts_en  = 1'b1;
                new_msg.marker = 1'b0;
            end
            VAR_MARK: begin
                new_msg.ts_en  = 1'b0;
                new_msg.marker = 1'b1;
            end
            VAR_BOTH: begin
                new_msg.ts_en  = 1'b1;
                new_msg.marker = 1'b1;
            end
        endcase
        new_msg.ts = new_msg.ts_en ? ts_now : '0;
    end

    assign accept = wr_valid && wr_ready;
    assign push   = accept && in_win;
    assign pop    = msg_valid && msg_ready;

    stg_msg_fifo #(
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .din_i  (new_msg),
        .pop_i  (pop),
        .dout_o (head_msg),
        .empty_o(fifo_empty),
        .count_o(fifo_count)
    );

    // Ingress state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ING_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: fill and drain transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ING_OPEN: begin
                if (push && !pop && fifo_count == CNT_W'(DEPTH - 1)) begin
                    state_d = ING_BLOCKED;
                end
            end
            ING_BLOCKED: begin
                if (pop) begin
                    state_d = ING_OPEN;
                end
            end
        endcase
    end

    // Outputs of the ingress machine
    always_comb begin
        unique case (state_q)
            ING_OPEN:    wr_ready = 1'b1;
            ING_BLOCKED: wr_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (accept && !in_win) begin
            err_q <= 1'b1;
        end
    end

    assign err_sticky  = err_q;
    assign msg_valid   = !fifo_empty;
    assign msg_chan    = head_msg.chan[CH_W-1:0];
    assign msg_data    = head_msg.data;
    assign msg_size    = head_msg.size;
    assign msg_ts_en   = head_msg.ts_en;
    assign msg_ts      = head_msg.ts;
    assign msg_marker  = head_msg.marker;
    assign unused_head = ^head_msg.chan;

endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
    parameter int          ADDR_W   = 32,
    parameter int          CH_W     = 4,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [CH_W-1:0]   msg_chan,
    input logic [63:0]       msg_data,
    input logic [1:0]        msg_size,
    input logic              msg_ts_en,
    input logic [31:0]       msg_ts,
    input logic              msg_marker,
    input logic              err_sticky
);

    localparam int HI_LSB = CH_W + 8;

    logic [ADDR_W-1:0] base_ext;
    logic              miss;

    assign base_ext = ADDR_W'(WIN_BASE);
    assign miss     = (wr_addr >> HI_LSB) != (base_ext >> HI_LSB);

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_chan) && $stable(msg_ts) && $stable(msg_marker) && $stable(msg_size)); // R7

    AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R8

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && miss |=> err_sticky); // R8

    AST_MISS_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && miss && !msg_valid |=> !msg_valid); // R8

    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> wr_ready); // R10

    AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_size == 2'd0 |-> msg_data[63:8] == 56'd0); // R4

    AST_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_size == 2'd2 |-> msg_data[63:32] == 32'd0); // R4

    AST_NO_STAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ts_en |-> msg_ts == 32'd0); // R5

endmodule

bind sys_trace_gen stg_checker #(
    .ADDR_W  (ADDR_W),
    .CH_W    (CH_W),
    .WIN_BASE(WIN_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_chan  (msg_chan),
    .msg_data  (msg_data),
    .msg_size  (msg_size),
    .msg_ts_en (msg_ts_en),
    .msg_ts    (msg_ts),
    .msg_marker(msg_marker),
    .err_sticky(err_sticky)
);

// File: tb/sys_trace_gen_tb_top.sv
module sys_trace_gen_tb_top;

    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_size = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [3:0]  msg_chan;
    logic [63:0] msg_data;
    logic [1:0]  msg_size;
    logic        msg_ts_en;
    logic [31:0] msg_ts;
    logic        msg_marker;
    logic        err_sticky;

    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    int          acc_cyc = 0;
    logic [31:0] got_ts = '0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sys_trace_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size(wr_size),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_chan(msg_chan),
        .msg_data(msg_data), .msg_size(msg_size), .msg_ts_en(msg_ts_en),
        .msg_ts(msg_ts), .msg_marker(msg_marker), .err_sticky(err_sticky)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] keep(input logic [1:0] sz, input logic [63:0] d);
        case (sz)
            2'd0:    return {56'd0, d[7:0]};
            2'd1:    return {48'd0, d[15:0]};
            2'd2:    return {32'd0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] adr(input int ch, input int vr, input logic [7:0] extra);
        return BASE | (32'(ch) << 8) | (32'(vr) << 3) | 32'(extra);
    endfunction

    task automatic do_write(input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        wr_size  = sz;
        while (!wr_ready) @(negedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_msg(input string req, input int ch, input logic [63:0] d,
                              input logic [1:0] sz, input bit ts_en, input bit mk);
        int waitn = 0;
        @(negedge clk);
        while (!msg_valid && waitn < 50) begin
            @(negedge clk);
            waitn++;
        end
        check(msg_valid, {req, " msg_valid"}, 64'(msg_valid), 64'd1);
        check(msg_chan == 4'(ch), {req, " chan"}, 64'(msg_chan), 64'(ch));
        check(msg_data == keep(sz, d), {req, " data"}, msg_data, keep(sz, d));
        check(msg_size == sz, {req, " size"}, 64'(msg_size), 64'(sz));
        check(msg_ts_en == ts_en, {req, " ts_en"}, 64'(msg_ts_en), 64'(ts_en));
        check(msg_marker == mk, {req, " marker"}, 64'(msg_marker), 64'(mk));
        if (!ts_en) check(msg_ts == 32'd0, {req, " R5 unstamped ts"}, 64'(msg_ts), 64'd0);
        got_ts = msg_ts;
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(msg_valid == 1'b0, "R9 msg_valid", 64'(msg_valid), 64'd0);
        check(err_sticky == 1'b0, "R9 err_sticky", 64'(err_sticky), 64'd0);
        check(wr_ready == 1'b1, "R9 wr_ready", 64'(wr_ready), 64'd1);
    endtask

    task automatic t_basic();
        do_write(adr(3, 0, 8'h00), 64'hDEAD_BEEF_0123_4567, 2'd3);
        expect_msg("R1 R2 basic", 3, 64'hDEAD_BEEF_0123_4567, 2'd3, 1'b0, 1'b0);
        do_write(adr(15, 0, 8'h00), 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
        expect_msg("R4 size8", 15, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 1'b0);
        do_write(adr(7, 0, 8'h00), 64'hAAAA_BBBB_CCCC_DDDD, 2'd1);
        expect_msg("R4 size16", 7, 64'hAAAA_BBBB_CCCC_DDDD, 2'd1, 1'b0, 1'b0);
        do_write(adr(0, 0, 8'h00), 64'h1234_5678_9ABC_DEF0, 2'd2);
        expect_msg("R4 size32", 0, 64'h1234_5678_9ABC_DEF0, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_variants();
        int c1;
        int c2;
        logic [31:0] ts1;
        do_write(adr(1, 1, 8'h00), 64'h11, 2'd3);
        c1 = acc_cyc;
        repeat (5) @(negedge clk);
        do_write(adr(2, 3, 8'hE5), 64'h22, 2'd3);
        c2 = acc_cyc;
        expect_msg("R3 stamp", 1, 64'h11, 2'd3, 1'b1, 1'b0);
        ts1 = got_ts;
        expect_msg("R3 both alias", 2, 64'h22, 2'd3, 1'b1, 1'b1);
        check(got_ts - ts1 == 32'(c2 - c1), "R5 ts distance", 64'(got_ts - ts1), 64'(c2 - c1));
        do_write(adr(9, 2, 8'h00), 64'h33, 2'd0);
        expect_msg("R3 marker", 9, 64'h33, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_backpressure();
        logic [63:0] held;
        for (int i = 0; i < 4; i++) begin
            do_write(adr(i + 4, 0, 8'h00), 64'h100 + 64'(i), 2'd3);
        end
        check(wr_ready == 1'b0, "R6 stall when full", 64'(wr_ready), 64'd0);
        held = msg_data;
        repeat (3) @(negedge clk);
        check(msg_data == held, "R7 held data", msg_data, held);
        expect_msg("R6 R2 order 0", 4, 64'h100, 2'd3, 1'b0, 1'b0);
        check(wr_ready == 1'b1, "R10 reopen after drain", 64'(wr_ready), 64'd1);
        do_write(adr(8, 0, 8'h00), 64'h104, 2'd3);
        for (int i = 1; i < 5; i++) begin
            expect_msg("R6 R2 order", i + 4, 64'h100 + 64'(i), 2'd3, 1'b0, 1'b0);
        end
        check(msg_valid == 1'b0, "R2 no extra message", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_outside();
        do_write(32'h5000_0010, 64'h77, 2'd3);
        check(err_sticky == 1'b1, "R8 err set", 64'(err_sticky), 64'd1);
        check(msg_valid == 1'b0, "R8 no message", 64'(msg_valid), 64'd0);
        do_write(adr(5, 0, 8'h00), 64'h88, 2'd3);
        expect_msg("R8 later write", 5, 64'h88, 2'd3, 1'b0, 1'b0);
        check(err_sticky == 1'b1, "R8 err stays", 64'(err_sticky), 64'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_variants();
        t_backpressure();
        t_outside();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule